// File: doc/BRIEF.md
# Serial Receive Status and Holding Register

This block is the receive-side bookkeeping of a serial port. A receive shift register hands it completed characters. Each one arrives as a one-cycle strobe that is qualified by valid framing. A line sampler reports whether the line is idle. The block keeps the most recent accepted character in a holding register. It tracks three sticky flags:

- a holding-full flag, set when a character is accepted;
- an overrun flag, set when a character arrives while the holding register is still full;
- an idle flag, set when the line goes idle after traffic.

Software reads a status word and the holding register over a simple one-cycle read port. Software never writes the flags. It clears them with an ordered pair of reads: a status read arms the clear of each flag that the read saw set, and the next holding-register read clears the armed flags. A character that arrives between the two reads cannot be cleared by a pair whose status read did not see it. Two interrupt requests are brought out, each gated by its own enable input: an error request for overrun, and a receive request for holding-full.

Top module: `rx_status_unit`

## Requirements
- R1: While the synchronous active-low reset is asserted, all three flags, the armed bits, the idle re-arm latch and the holding register become zero. After reset the status word and the holding register read as 0.
- R2: The read data is combinational in the same cycle. `rd_sel`=1 selects the holding register and `rd_sel`=0 selects the status word, whose bit 0 is holding-full, bit 1 is overrun and bit 2 is idle, with the upper bits zero. An accepted character is loaded into the holding register and sets holding-full on the next clock edge.
- R3: A character that completes while holding-full is set, and is not cleared in that cycle, sets overrun. That character is dropped, and the holding register keeps its value.
- R4: Holding-full clears after a status read that saw it set, followed by a holding-register read. The next character that is accepted after that is the one the next holding-register read returns.
- R5: Overrun clears only after a status read that saw it set, followed by a holding-register read. If the status read saw it clear, the holding-register read leaves it set for the next pair.
- R6: Each flag captures its own armed bit at every status read. A status read that sees a flag clear disarms that flag, so a later holding-register read does not clear that flag even if the flag has since been set.
- R7: The idle flag is set when the line is idle, but only after a character has been accepted since the last idle clear. If the line stays idle after the clear, the flag stays 0 until a new character arrives.
- R8: The idle flag clears through the same status-then-holding read pair, armed by a status read that saw idle set.
- R9: `err_irq` is high exactly when overrun is set and `ovr_ie` is high.
- R10: `rx_irq` is high exactly when holding-full is set and `rx_ie` is high. It is a level, not a pulse.
- R11: A character that completes in the same cycle as a holding-register read that clears holding-full is accepted, not counted as overrun. Holding-full stays set, and the register takes the new character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_done | input | 1 | One-cycle strobe: a validly framed character has completed |
| char_data | input | DW | Character that accompanies `char_done` |
| line_idle | input | 1 | Receive line currently idle |
| rd_en | input | 1 | Read access in this cycle |
| rd_sel | input | 1 | 0 selects the status word, 1 selects the holding register |
| rd_data | output | DW | Combinational read data |
| ovr_ie | input | 1 | Error interrupt enable for overrun |
| rx_ie | input | 1 | Receive interrupt enable for holding-full |
| err_irq | output | 1 | Error interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach is a race against the read pair. In one form, a character lands between a status read that saw overrun clear and the holding read that follows, so overrun must survive that read. In the other, a character lands in the very cycle of a clearing holding read. Both depend on the exact order of reads and arrivals, so the bench applies every five-step sequence drawn from six operations: nothing, character, status read, holding read, idle line, and character together with holding read. It applies each sequence from reset, with the enable pair cycling across sequences, and compares the ports each cycle against an arithmetic model of the flags and armed bits.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int NFLAG   = 3;
  localparam int F_FULL  = 0;
  localparam int F_OVR   = 1;
  localparam int F_IDLE  = 2;

  // Status word: flag vector in the low bits, zero above.
  function automatic logic [31:0] pack_status(input logic [NFLAG-1:0] flags);
    logic [31:0] w;
    w = '0;
    w[NFLAG-1:0] = flags;
    return w;
  endfunction

  // A character is accepted when the holding register is free or is being freed.
  function automatic logic accept_char(input logic done, input logic full, input logic clr);
    return done && !(full && !clr);
  endfunction
endpackage

// File: rtl/rsf_flag_cell.sv
module rsf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, armed_q, clr_w;

  assign clr_w = data_rd_i && armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_i)      flag_q <= 1'b1;
      else if (clr_w) flag_q <= 1'b0;
      if (stat_rd_i)      armed_q <= flag_q;
      else if (data_rd_i) armed_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;

  // R5
  fell_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(data_rd_i && armed_q));
  // R6
  arm_from_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(stat_rd_i && flag_q));
endmodule

// File: rtl/rsf_hold_reg.sv
module rsf_hold_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      hold_q <= '0;
    else if (load_i) hold_q <= din_i;
  end

  assign dout_o = hold_q;

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(hold_q));
endmodule

// File: rtl/rsf_idle_gate.sv
module rsf_idle_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic line_idle_i,
  input  logic clr_idle_i,
  output logic set_idle_o,
  output logic rearm_o
);
  logic rearm_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          rearm_q <= 1'b0;
    else if (accept_i)   rearm_q <= 1'b1;
    else if (clr_idle_i) rearm_q <= 1'b0;
  end

  assign set_idle_o = line_idle_i && rearm_q && !clr_idle_i;
  assign rearm_o    = rearm_q;

  // R7
  rearm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rearm_q) |-> $past(accept_i));
endmodule

// File: rtl/rx_status_unit.sv
module rx_status_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_done,
  input  logic [DW-1:0] char_data,
  input  logic          line_idle,
  input  logic          rd_en,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          ovr_ie,
  input  logic          rx_ie,
  output logic          err_irq,
  output logic          rx_irq
);
  import rsf_pkg::*;

  localparam int SW = (DW < NFLAG) ? NFLAG : DW;

  logic             stat_rd, data_rd;
  logic [NFLAG-1:0] flag_v, armed_v, set_v, clr_v;
  logic             accept, overrun_evt, set_idle, rearm;
  logic [DW-1:0]    hold;
  logic [31:0]      status_w;

  assign stat_rd = rd_en && !rd_sel;
  assign data_rd = rd_en &&  rd_sel;

  // Named clear events, one per flag.
  assign clr_v = armed_v & {NFLAG{data_rd}};

  assign accept      = accept_char(char_done, flag_v[F_FULL], clr_v[F_FULL]);
  assign overrun_evt = char_done && !accept;

  assign set_v[F_FULL] = accept;
  assign set_v[F_OVR]  = overrun_evt;
  assign set_v[F_IDLE] = set_idle;

  genvar gi;
  generate
    for (gi = 0; gi < NFLAG; gi++) begin : g_flag
      rsf_flag_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_v[gi]),
        .stat_rd_i (stat_rd),
        .data_rd_i (data_rd),
        .flag_o    (flag_v[gi]),
        .armed_o   (armed_v[gi])
      );
    end
  endgenerate

  rsf_hold_reg #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .din_i  (char_data),
    .dout_o (hold)
  );

  rsf_idle_gate u_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .line_idle_i (line_idle),
    .clr_idle_i  (clr_v[F_IDLE]),
    .set_idle_o  (set_idle),
    .rearm_o     (rearm)
  );

  assign status_w = pack_status(flag_v);

  always_comb begin
    if (rd_sel) rd_data = hold;
    else        rd_data = status_w[DW-1:0];
  end

  assign err_irq = flag_v[F_OVR]  && ovr_ie;
  assign rx_irq  = flag_v[F_FULL] && rx_ie;

  // R3
  overrun_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && flag_v[F_FULL] && !clr_v[F_FULL]) |=> (flag_v[F_OVR] && $stable(hold)));
  // R11
  load_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && clr_v[F_FULL]) |=> (flag_v[F_FULL] && hold == $past(char_data)));
  // R7
  idle_needs_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_v[F_IDLE]) |-> $past(rearm && line_idle));
  // R9
  err_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (ovr_ie && rd_sel) || (ovr_ie && status_w[F_OVR]));
  // R10
  rx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> (rx_ie && ($past(accept) || $rose(rx_ie))));
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (flag_v == '0 && armed_v == '0 && hold == '0 && !rearm));
endmodule

// File: tb/rx_status_unit_test.sv
`timescale 1ns/1ps
module rx_status_unit_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic char_done = 1'b0;
  logic [DW-1:0] char_data = '0;
  logic line_idle = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic ovr_ie = 1'b0, rx_ie = 1'b0;
  logic [DW-1:0] rd_data;
  logic err_irq, rx_irq;

  int vectors = 0;
  int miscompares = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  rx_status_unit #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
    .line_idle(line_idle), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .ovr_ie(ovr_ie), .rx_ie(rx_ie), .err_irq(err_irq), .rx_irq(rx_irq)
  );

  // Bench model of the flags, armed bits, re-arm latch and holding register.
  bit m_full, m_ovr, m_idl, m_rearm, a_full, a_ovr, a_idl;
  logic [DW-1:0] m_hold;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_full = 0; m_ovr = 0; m_idl = 0; m_rearm = 0;
    a_full = 0; a_ovr = 0; a_idl = 0; m_hold = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; char_done = 0; rd_en = 0; rd_sel = 0; line_idle = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // One cycle: drive at negedge, compare ports, advance the model to the next edge.
  task automatic step(input bit cd, input logic [DW-1:0] cdat, input bit li,
                      input bit ren, input bit sel);
    bit srd, drd, c_full, c_ovr, c_idl, busy, acc;
    @(negedge clk);
    char_done = cd; char_data = cdat; line_idle = li; rd_en = ren; rd_sel = sel;
    #2;
    if (sel) chk("R2 holding register", rd_data, m_hold);
    else begin
      chk("R4 full bit0", {7'b0, rd_data[0]}, {7'b0, m_full});
      chk("R5 overrun bit1", {7'b0, rd_data[1]}, {7'b0, m_ovr});
      chk("R7 idle bit2", {7'b0, rd_data[2]}, {7'b0, m_idl});
      chk("R2 status upper zero", {3'b0, rd_data[7:3]}, 8'h00);
    end
    chk("R9 err_irq", {7'b0, err_irq}, {7'b0, (m_ovr && ovr_ie)});
    chk("R10 rx_irq", {7'b0, rx_irq}, {7'b0, (m_full && rx_ie)});
    srd = ren && !sel; drd = ren && sel;
    c_full = drd && a_full; c_ovr = drd && a_ovr; c_idl = drd && a_idl;
    busy = m_full && !c_full;
    acc  = cd && !busy;
    if (srd) begin a_full = m_full; a_ovr = m_ovr; a_idl = m_idl; end
    else if (drd) begin a_full = 0; a_ovr = 0; a_idl = 0; end
    if (c_idl) m_idl = 0; else if (li && m_rearm) m_idl = 1;
    if (acc) m_rearm = 1; else if (c_idl) m_rearm = 0;
    if (acc) begin m_full = 1; m_hold = cdat; end else if (c_full) m_full = 0;
    if (cd && busy) m_ovr = 1; else if (c_ovr) m_ovr = 0;
  endtask

  task automatic peek(input bit sel, input bit li);
    step(1'b0, 8'h00, li, 1'b0, sel);
  endtask

  task automatic apply_op(input int op, input logic [DW-1:0] d);
    case (op)
      0: step(0, d, 0, 0, 0);
      1: step(1, d, 0, 0, 0);
      2: step(0, d, 0, 1, 0);
      3: step(0, d, 0, 1, 1);
      4: step(0, d, 1, 0, 0);
      default: step(1, d, 0, 1, 1);
    endcase
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    ovr_ie = 1; rx_ie = 1;
    do_reset();
    // R1: reset state
    peek(1, 0); chk("R1 holding after reset", rd_data, 8'h00);
    peek(0, 0); chk("R1 status after reset", rd_data, 8'h00);
    chk("R1 irqs after reset", {6'b0, err_irq, rx_irq}, 8'h00);
    // R7: idle line before any character leaves idle clear
    peek(0, 1); peek(0, 0); chk("R7 no idle before character", rd_data, 8'h00);
    // R2: accept a character
    step(1, 8'h11, 0, 0, 0);
    peek(0, 0); chk("R2 full after character", rd_data, 8'h01);
    chk("R10 rx_irq level", {7'b0, rx_irq}, 8'h01);
    // Status read sees full only, then overrun arrives
    step(0, 0, 0, 1, 0); chk("R2 status read value", rd_data, 8'h01);
    step(1, 8'h22, 0, 0, 0);
    peek(0, 0); chk("R3 overrun set", rd_data, 8'h03);
    chk("R9 err_irq on overrun", {7'b0, err_irq}, 8'h01);
    step(0, 0, 0, 1, 1); chk("R3 holding kept", rd_data, 8'h11);
    peek(0, 0); chk("R5 overrun survives unarmed pair", rd_data, 8'h02);
    chk("R4 full cleared by pair", {7'b0, rd_data[0]}, 8'h00);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 1);
    peek(0, 0); chk("R5 overrun cleared by armed pair", rd_data, 8'h00);
    // R6: status read sees full clear, character arrives, data read does not clear
    step(0, 0, 0, 1, 0);
    step(1, 8'h33, 0, 0, 0);
    step(0, 0, 0, 1, 1); chk("R4 next character returned", rd_data, 8'h33);
    peek(0, 0); chk("R6 disarmed full not cleared", rd_data, 8'h01);
    // R11: character on the clearing read
    step(0, 0, 0, 1, 0);
    step(1, 8'h55, 0, 1, 1); chk("R11 read returns old", rd_data, 8'h33);
    peek(1, 0); chk("R11 new character loaded", rd_data, 8'h55);
    peek(0, 0); chk("R11 no overrun", rd_data, 8'h01);
    // R7 / R8: idle after traffic, cleared by pair, not re-set without a character
    step(0, 0, 1, 0, 0);
    peek(0, 1); chk("R7 idle set after traffic", rd_data, 8'h05);
    step(0, 0, 1, 1, 0);
    step(0, 0, 1, 1, 1);
    peek(0, 1); chk("R8 idle cleared by pair", rd_data, 8'h00);
    peek(0, 1); peek(0, 0); chk("R7 idle held off until new character", rd_data, 8'h00);

    // Sweep: every five-step sequence over six operations, enables cycling.
    for (int idx = 0; idx < 7776; idx++) begin
      int code;
      code = idx;
      ovr_ie = idx[0]; rx_ie = idx[1];
      do_reset();
      for (int k = 0; k < 5; k++) begin
        apply_op(code % 6, 8'((idx * 7) + k + 1));
        code = code / 6;
      end
      peek(0, 0);
      peek(1, 0);
    end

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule